// File: doc/BRIEF.md
# Framed link packet receiver

This block sits behind the capture flops of a narrow source-synchronous link. Each clock it takes one byte together with a frame qualifier. A rising edge of the frame qualifier marks the first byte of a transaction. The block rebuilds each transaction into a 104-bit packet using the same field layout as the transmit side. It also follows bursts, where the sender keeps the frame high and streams further 64-bit payloads that reuse the last header.

Completed packets are sorted into three output channels: writes, read requests and read responses. Each channel has a small holding buffer and an access/wait handshake toward the system. The block drives two back-pressure lines toward the sender, one for the write class and one for the read class. Each line rises as soon as any packet is buffered on its channels, so the sender gets its warning while room for exactly one more transaction remains. A packet that arrives at a buffer that is full and not draining is dropped, and the block raises an overflow pulse for that channel.

Top module: `flink_rx`

## Requirements
- R1: A byte is taken as the first (ignored) byte of a transaction only when `rx_frame` is high in that cycle and was low in the cycle before; no packet is produced from bytes seen while the frame is low.
- R2: The five header bytes that follow are decoded as {ctrl[3:0], dst[31:28]}, dst[27:20], dst[19:12], dst[11:4], {dst[3:0], size[1:0], write, valid}. They are placed in the packet at valid=bit 0, write=bit 1, size=bits 3:2, ctrl=bits 7:4 and dst=bits 39:8.
- R3: The next four bytes form one 32-bit word, most significant byte first. For a write it goes to packet bits 71:40 and bits 103:72 are zero. For a read request it goes to bits 103:72 (return address) and bits 71:40 are zero.
- R4: A write with size 2'b11 (64-bit) carries four more bytes, most significant first, that go to packet bits 103:72; its packet is complete only after the thirteenth byte after the first.
- R5: If the frame is still high after the last byte of a 64-bit write, the following bytes form a new packet. It uses the same header, and its destination is the previous destination plus 8. This repeats for as long as the frame stays high.
- R6: Reads and writes that are not 64-bit are complete after the ninth byte after the first. Any further bytes received while the frame stays high are ignored and produce no packet.
- R7: A packet whose ctrl field equals 4'b1111 goes to the read-response channel. Any other write goes to the write channel, and any other read goes to the read-request channel.
- R8: Each channel holds `*_access` high with a stable `*_packet` while its `*_wait` input is high. It hands over one packet per cycle in which access is high and wait is low, in arrival order.
- R9: `link_wr_wait` is high one cycle after the write or read-response buffer holds at least one packet. `link_rd_wait` does the same for the read-request buffer alone, and the two lines are independent.
- R10: Each channel holds two packets. A packet that arrives while its channel holds two and does not hand one over in that cycle is dropped, and the channel's `overflow` bit is high for one cycle; the two held packets are kept.
- R11: A packet that completes in the same cycle as its full channel hands one over is stored without overflow.
- R12: While `rst` is high and right after it, all access, wait and overflow outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_frame | input | 1 | Frame qualifier from the link |
| rx_byte | input | 8 | Captured link byte |
| link_wr_wait | output | 1 | Back-pressure to sender for writes |
| link_rd_wait | output | 1 | Back-pressure to sender for read requests |
| wr_access | output | 1 | Write channel holds a packet |
| wr_packet | output | 104 | Write channel packet |
| wr_wait | input | 1 | Write channel stall from system |
| rd_access | output | 1 | Read-request channel holds a packet |
| rd_packet | output | 104 | Read-request channel packet |
| rd_wait | input | 1 | Read-request channel stall from system |
| rr_access | output | 1 | Read-response channel holds a packet |
| rr_packet | output | 104 | Read-response channel packet |
| rr_wait | input | 1 | Read-response channel stall from system |
| overflow | output | 3 | One-cycle drop pulse per channel (bit 0 write, 1 read, 2 read response) |

## Verification
The collision that matters is a packet completing in the very cycle that a full holding buffer hands its oldest entry to the system. The bench fills the write buffer with its stall held high. It then sends a third write and lowers the stall on the falling edge that follows that packet's last byte, so the store and the hand-over share one rising edge. The result is judged at the ports: there must be no overflow pulse, and all three packets must come out in order with their fields intact. The plain overflow case, where the stall stays high, is run as a contrast.

// File: rtl/flink_pkg.sv
package flink_pkg;

  localparam int PKT_W  = 104;
  localparam int NUM_CH = 3;
  localparam int CH_WR  = 0;
  localparam int CH_RD  = 1;
  localparam int CH_RR  = 2;

  // packet layout, MSB first: return/upper word, data word, destination,
  // ctrl, size, write, valid
  typedef struct packed {
    logic [31:0] upper;
    logic [31:0] data;
    logic [31:0] dst;
    logic [3:0]  ctrl;
    logic [1:0]  size;
    logic        write;
    logic        valid;
  } pkt_t;

  localparam logic [1:0] SIZE_64 = 2'b11;

endpackage

// File: rtl/flink_rx_deframer.sv
module flink_rx_deframer
  import flink_pkg::*;
#(
  parameter logic [3:0] RR_CTRL = 4'b1111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_frame,
  input  logic [7:0] rx_byte,
  output logic       pkt_valid,
  output pkt_t       pkt,
  output logic [1:0] pkt_chan
);

  localparam logic [3:0] POS_LAST32 = 4'd9;
  localparam logic [3:0] POS_LAST64 = 4'd13;
  localparam logic [3:0] POS_BURST  = 4'd6;
  localparam logic [3:0] POS_SKIP   = 4'd15;
  localparam logic [31:0] BURST_STEP = 32'd8;

  logic        f1, f2;
  logic [7:0]  b1;
  logic        active;
  logic [3:0]  pos;
  logic [3:0]  ctrl_q;
  logic [31:0] dst_q;
  logic [1:0]  size_q;
  logic        wr_q, vld_q;
  logic [31:0] lo_q, hi_q;

  logic        start;
  logic        is64;
  logic [31:0] lo_now, hi_now;

  assign start  = f1 & ~f2;
  assign is64   = wr_q && (size_q == SIZE_64);
  assign lo_now = {lo_q[23:0], b1};
  assign hi_now = {hi_q[23:0], b1};

  // input capture stage and frame history
  always_ff @(posedge clk) begin
    if (rst) begin
      f1 <= 1'b0;
      f2 <= 1'b0;
      b1 <= '0;
    end else begin
      f1 <= rx_frame;
      f2 <= f1;
      b1 <= rx_byte;
    end
  end

  // byte position tracking and field gathering
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pos    <= '0;
      ctrl_q <= '0;
      dst_q  <= '0;
      size_q <= '0;
      wr_q   <= 1'b0;
      vld_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (start) begin
      active <= 1'b1;
      pos    <= 4'd1;
    end else if (!f1) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (active) begin
      case (pos)
        4'd1: begin
          ctrl_q        <= b1[7:4];
          dst_q[31:28]  <= b1[3:0];
          pos           <= pos + 4'd1;
        end
        4'd2: begin
          dst_q[27:20]  <= b1;
          pos           <= pos + 4'd1;
        end
        4'd3: begin
          dst_q[19:12]  <= b1;
          pos           <= pos + 4'd1;
        end
        4'd4: begin
          dst_q[11:4]   <= b1;
          pos           <= pos + 4'd1;
        end
        4'd5: begin
          dst_q[3:0]    <= b1[7:4];
          size_q        <= b1[3:2];
          wr_q          <= b1[1];
          vld_q         <= b1[0];
          pos           <= pos + 4'd1;
        end
        4'd6, 4'd7, 4'd8: begin
          lo_q <= lo_now;
          pos  <= pos + 4'd1;
        end
        POS_LAST32: begin
          lo_q <= lo_now;
          pos  <= is64 ? 4'd10 : POS_SKIP;
        end
        4'd10, 4'd11, 4'd12: begin
          hi_q <= hi_now;
          pos  <= pos + 4'd1;
        end
        POS_LAST64: begin
          hi_q  <= hi_now;
          dst_q <= dst_q + BURST_STEP;
          pos   <= POS_BURST;
        end
        default: pos <= pos;
      endcase
    end
  end

  // packet completion and assembly
  always_comb begin
    pkt_valid = active && f1 && !start &&
                (((pos == POS_LAST32) && !is64) || (pos == POS_LAST64));
    pkt.ctrl  = ctrl_q;
    pkt.dst   = dst_q;
    pkt.size  = size_q;
    pkt.write = wr_q;
    pkt.valid = vld_q;
    if (pos == POS_LAST64) begin
      pkt.data  = lo_q;
      pkt.upper = hi_now;
    end else if (wr_q) begin
      pkt.data  = lo_now;
      pkt.upper = '0;
    end else begin
      pkt.data  = '0;
      pkt.upper = lo_now;
    end
    if (ctrl_q == RR_CTRL)
      pkt_chan = 2'(CH_RR);
    else if (wr_q)
      pkt_chan = 2'(CH_WR);
    else
      pkt_chan = 2'(CH_RD);
  end

  // R1: a completed packet always stems from a byte taken with frame high
  p_pkt_needs_frame_r1: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> $past(rx_frame));

  // R6: after a short packet completes, no packet follows until a new frame
  p_no_trailing_pkt_r6: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !is64) |=> !pkt_valid);

endmodule

// File: rtl/flink_hold_buf.sv
module flink_hold_buf #(
  parameter int W       = 104,
  parameter int DEPTH   = 2,
  parameter int WAIT_AT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_access,
  output logic [W-1:0] out_data,
  input  logic         out_wait,
  output logic         near_full,
  output logic         ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] WAIT_CNT = CW'(WAIT_AT);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_next;
  logic          acc_q;
  logic          pop, room, do_push;

  assign pop     = acc_q && !out_wait;
  assign room    = (cnt < FULL_CNT) || pop;
  assign do_push = push && room;

  always_comb begin
    cnt_next = cnt;
    if (do_push && !pop)
      cnt_next = cnt + CW'(1);
    else if (pop && !do_push)
      cnt_next = cnt - CW'(1);
  end

  // storage: written only, read through a registered pointer
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      acc_q     <= 1'b0;
      near_full <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (do_push)
        wptr <= (wptr == LAST_PTR) ? '0 : wptr + AW'(1);
      if (pop)
        rptr <= (rptr == LAST_PTR) ? '0 : rptr + AW'(1);
      cnt       <= cnt_next;
      acc_q     <= (cnt_next != '0);
      near_full <= (cnt_next >= WAIT_CNT);
      ovf       <= push && !room;
    end
  end

  assign out_access = acc_q;
  assign out_data   = mem[rptr];

  // R8: a stalled packet stays presented unchanged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (out_access && out_wait) |=> (out_access && $stable(out_data)));

  // R10: a drop is only reported for a stalled, occupied buffer
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(out_access) && $past(out_wait)));

endmodule

// File: rtl/flink_rx.sv
module flink_rx
  import flink_pkg::*;
#(
  parameter int         BUF_DEPTH = 2,
  parameter int         WAIT_AT   = 1,
  parameter logic [3:0] RR_CTRL   = 4'b1111
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_frame,
  input  logic [7:0]   rx_byte,
  output logic         link_wr_wait,
  output logic         link_rd_wait,
  output logic         wr_access,
  output logic [103:0] wr_packet,
  input  logic         wr_wait,
  output logic         rd_access,
  output logic [103:0] rd_packet,
  input  logic         rd_wait,
  output logic         rr_access,
  output logic [103:0] rr_packet,
  input  logic         rr_wait,
  output logic [2:0]   overflow
);

  logic       pkt_valid;
  pkt_t       pkt;
  logic [1:0] pkt_chan;

  logic [NUM_CH-1:0] ch_push, ch_acc, ch_wait, ch_nf, ch_ovf;
  logic [PKT_W-1:0]  ch_data [NUM_CH];

  flink_rx_deframer #(.RR_CTRL(RR_CTRL)) deframer_i (
    .clk       (clk),
    .rst       (rst),
    .rx_frame  (rx_frame),
    .rx_byte   (rx_byte),
    .pkt_valid (pkt_valid),
    .pkt       (pkt),
    .pkt_chan  (pkt_chan)
  );

  assign ch_wait[CH_WR] = wr_wait;
  assign ch_wait[CH_RD] = rd_wait;
  assign ch_wait[CH_RR] = rr_wait;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign ch_push[g] = pkt_valid && (pkt_chan == 2'(g));
    flink_hold_buf #(
      .W       (PKT_W),
      .DEPTH   (BUF_DEPTH),
      .WAIT_AT (WAIT_AT)
    ) buf_i (
      .clk        (clk),
      .rst        (rst),
      .push       (ch_push[g]),
      .push_data  (pkt),
      .out_access (ch_acc[g]),
      .out_data   (ch_data[g]),
      .out_wait   (ch_wait[g]),
      .near_full  (ch_nf[g]),
      .ovf        (ch_ovf[g])
    );
  end

  // back-pressure toward the sender, write class and read class
  always_ff @(posedge clk) begin
    if (rst) begin
      link_wr_wait <= 1'b0;
      link_rd_wait <= 1'b0;
    end else begin
      link_wr_wait <= ch_nf[CH_WR] | ch_nf[CH_RR];
      link_rd_wait <= ch_nf[CH_RD];
    end
  end

  assign wr_access = ch_acc[CH_WR];
  assign rd_access = ch_acc[CH_RD];
  assign rr_access = ch_acc[CH_RR];
  assign wr_packet = ch_data[CH_WR];
  assign rd_packet = ch_data[CH_RD];
  assign rr_packet = ch_data[CH_RR];
  assign overflow  = ch_ovf;

  // R9: write-class wait only rises when that class has buffered packets
  p_wrwait_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(link_wr_wait) |-> $past(wr_access || rr_access));

  // R9: read-class wait only rises when read requests are buffered
  p_rdwait_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(link_rd_wait) |-> $past(rd_access));

  // R10: a dropping channel still presents its held packets
  p_ovf_keeps_held_r10: assert property (@(posedge clk) disable iff (rst)
    (overflow != 3'b000) |-> ((overflow & ~{rr_access, rd_access, wr_access}) == 3'b000));

  // R7: at most one channel reports a drop per cycle
  p_single_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(overflow));

endmodule

// File: tb/flink_rx_tb_top.sv
module flink_rx_tb_top;

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [31:0] dst;
    logic [1:0]  size;
    logic        wr;
    logic [63:0] data;
    logic [31:0] src;
    logic [1:0]  ch;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 32'h8100_1234, 2'b10, 1'b1, 64'h0000_0000_DEAD_BEEF, 32'h0,         2'd0},
    '{4'h2, 32'h4567_89A8, 2'b10, 1'b0, 64'h0,                   32'hC0DE_0010, 2'd1},
    '{4'hF, 32'h9000_0400, 2'b10, 1'b1, 64'h0000_0000_1357_9BDF, 32'h0,         2'd2},
    '{4'h1, 32'hABCD_EF08, 2'b11, 1'b1, 64'h0102_0304_A0B0_C0D0, 32'h0,         2'd0},
    '{4'h0, 32'h0000_0003, 2'b00, 1'b1, 64'h0000_0000_0000_005A, 32'h0,         2'd0},
    '{4'h5, 32'h7000_0008, 2'b11, 1'b0, 64'h0,                   32'h8888_4444, 2'd1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rx_frame = 1'b0;
  logic [7:0]   rx_byte = '0;
  logic         link_wr_wait, link_rd_wait;
  logic         wr_access, rd_access, rr_access;
  logic [103:0] wr_packet, rd_packet, rr_packet;
  logic         wr_wait = 1'b0, rd_wait = 1'b0, rr_wait = 1'b0;
  logic [2:0]   overflow;

  always #2 clk = ~clk;

  flink_rx dut_i (
    .clk(clk), .rst(rst), .rx_frame(rx_frame), .rx_byte(rx_byte),
    .link_wr_wait(link_wr_wait), .link_rd_wait(link_rd_wait),
    .wr_access(wr_access), .wr_packet(wr_packet), .wr_wait(wr_wait),
    .rd_access(rd_access), .rd_packet(rd_packet), .rd_wait(rd_wait),
    .rr_access(rr_access), .rr_packet(rr_packet), .rr_wait(rr_wait),
    .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  logic [103:0] cap [3][16];
  int ncap [3] = '{0, 0, 0};
  int novf [3] = '{0, 0, 0};
  logic [7:0] bq [40];
  int blen;

  task automatic chk(input bit ok, input string tag, input logic [103:0] act,
                     input logic [103:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // observe transfers and drop pulses after inputs have settled
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (wr_access && !wr_wait) begin cap[0][ncap[0] % 16] = wr_packet; ncap[0]++; end
      if (rd_access && !rd_wait) begin cap[1][ncap[1] % 16] = rd_packet; ncap[1]++; end
      if (rr_access && !rr_wait) begin cap[2][ncap[2] % 16] = rr_packet; ncap[2]++; end
      for (int c = 0; c < 3; c++) if (overflow[c]) novf[c]++;
    end
  end

  function automatic logic [103:0] exp_pkt(input vec_t v);
    logic is64;
    logic [31:0] up, dw;
    is64 = v.wr && (v.size == 2'b11);
    up = v.wr ? (is64 ? v.data[63:32] : 32'h0) : v.src;
    dw = v.wr ? v.data[31:0] : 32'h0;
    return {up, dw, v.dst, v.ctrl, v.size, v.wr, 1'b1};
  endfunction

  task automatic put_word(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) begin bq[blen] = w[k*8 +: 8]; blen++; end
  endtask

  task automatic build(input vec_t v);
    blen = 0;
    bq[0] = 8'h00;
    bq[1] = {v.ctrl, v.dst[31:28]};
    bq[2] = v.dst[27:20];
    bq[3] = v.dst[19:12];
    bq[4] = v.dst[11:4];
    bq[5] = {v.dst[3:0], v.size, v.wr, 1'b1};
    blen = 6;
    put_word(v.wr ? v.data[31:0] : v.src);
    if (v.wr && v.size == 2'b11) put_word(v.data[63:32]);
  endtask

  task automatic send(input int extra, input bit drop_wr_wait);
    for (int k = 0; k < blen; k++) begin
      @(negedge clk);
      rx_frame = 1'b1;
      rx_byte  = bq[k];
    end
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      rx_byte = 8'hA5;
    end
    @(negedge clk);
    rx_frame = 1'b0;
    rx_byte  = 8'h00;
    if (drop_wr_wait) wr_wait = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
  end

  initial begin
    vec_t v, va, vb, vc;
    int b0, b1c, b2c, o0;
    logic [103:0] ea, eb, ec;

    // R12: reset state
    idle(3);
    chk({wr_access, rd_access, rr_access, link_wr_wait, link_rd_wait, overflow} == 8'h0,
        "R12 reset outputs", {96'h0, wr_access, rd_access, rr_access, link_wr_wait,
        link_rd_wait, overflow}, 104'h0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk({wr_access, rd_access, rr_access, link_wr_wait, link_rd_wait, overflow} == 8'h0,
        "R12 after reset", {96'h0, wr_access, rd_access, rr_access, link_wr_wait,
        link_rd_wait, overflow}, 104'h0);

    // table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      b0 = ncap[0]; b1c = ncap[1]; b2c = ncap[2];
      build(v);
      send((v.wr && v.size == 2'b11) ? 0 : 3, 1'b0);
      idle(5);
      chk((ncap[0] - b0) + (ncap[1] - b1c) + (ncap[2] - b2c) == 1,
          "R1/R6 one packet per frame", 104'((ncap[0] - b0) + (ncap[1] - b1c) + (ncap[2] - b2c)),
          104'd1);
      chk(ncap[v.ch] == ((v.ch == 0) ? b0 : (v.ch == 1) ? b1c : b2c) + 1,
          "R7 channel choice", 104'(ncap[v.ch]), 104'(((v.ch == 0) ? b0 : (v.ch == 1) ? b1c : b2c) + 1));
      chk(cap[v.ch][(ncap[v.ch] - 1) % 16] == exp_pkt(v), "R2/R3/R4 packet fields",
          cap[v.ch][(ncap[v.ch] - 1) % 16], exp_pkt(v));
    end

    // R5: burst of two 64-bit payloads under one header
    v = '{4'h3, 32'h1000_0040, 2'b11, 1'b1, 64'h1111_2222_3333_4444, 32'h0, 2'd0};
    vb = v; vb.dst = 32'h1000_0048; vb.data = 64'h5555_6666_7777_8888;
    build(v);
    put_word(vb.data[31:0]);
    put_word(vb.data[63:32]);
    b0 = ncap[0];
    send(0, 1'b0);
    idle(5);
    chk(ncap[0] == b0 + 2, "R5 burst count", 104'(ncap[0]), 104'(b0 + 2));
    chk(cap[0][b0 % 16] == exp_pkt(v), "R5 burst first", cap[0][b0 % 16], exp_pkt(v));
    chk(cap[0][(b0 + 1) % 16] == exp_pkt(vb), "R5 burst second dst+8",
        cap[0][(b0 + 1) % 16], exp_pkt(vb));

    // R8 R9 R10: stall the write channel and overfill it
    va = VECS[0];
    vb = VECS[0]; vb.dst = 32'h8100_2000; vb.data = 64'hAAAA_0001;
    vc = VECS[0]; vc.dst = 32'h8100_3000; vc.data = 64'hAAAA_0002;
    ea = exp_pkt(va); eb = exp_pkt(vb); ec = exp_pkt(vc);
    wr_wait = 1'b1;
    b0 = ncap[0]; o0 = novf[0];
    build(va); send(0, 1'b0); idle(3);
    chk(wr_access == 1'b1, "R8 access held", 104'(wr_access), 104'd1);
    chk(link_wr_wait == 1'b1 && link_rd_wait == 1'b0, "R9 write wait only",
        {102'h0, link_wr_wait, link_rd_wait}, 104'b10);
    build(vb); send(0, 1'b0); idle(3);
    build(vc); send(0, 1'b0); idle(3);
    chk(novf[0] == o0 + 1, "R10 overflow pulse", 104'(novf[0]), 104'(o0 + 1));
    idle(4);
    chk(wr_packet == ea && ncap[0] == b0, "R8 stable while stalled", wr_packet, ea);
    // read class is independent
    rd_wait = 1'b1;
    b1c = ncap[1];
    build(VECS[1]); send(0, 1'b0); idle(3);
    chk(link_rd_wait == 1'b1, "R9 read wait", 104'(link_rd_wait), 104'd1);
    rd_wait = 1'b0;
    idle(4);
    chk(link_rd_wait == 1'b0 && ncap[1] == b1c + 1, "R9 read wait clears",
        {103'h0, link_rd_wait}, 104'h0);
    wr_wait = 1'b0;
    idle(6);
    chk(ncap[0] == b0 + 2, "R10 dropped packet absent", 104'(ncap[0]), 104'(b0 + 2));
    chk(cap[0][b0 % 16] == ea && cap[0][(b0 + 1) % 16] == eb, "R10 held order",
        cap[0][(b0 + 1) % 16], eb);
    chk(link_wr_wait == 1'b0, "R9 write wait clears", 104'(link_wr_wait), 104'h0);

    // R11: completion coincides with hand-over from a full buffer
    wr_wait = 1'b1;
    b0 = ncap[0]; o0 = novf[0];
    build(va); send(0, 1'b0); idle(3);
    build(vb); send(0, 1'b0); idle(3);
    build(vc); send(0, 1'b1); idle(6);
    chk(novf[0] == o0, "R11 no overflow on same-cycle drain", 104'(novf[0]), 104'(o0));
    chk(ncap[0] == b0 + 3, "R11 all three delivered", 104'(ncap[0]), 104'(b0 + 3));
    chk(cap[0][(b0 + 2) % 16] == ec && cap[0][(b0 + 1) % 16] == eb,
        "R11 order kept", cap[0][(b0 + 2) % 16], ec);

    // R12: reset empties a stalled buffer
    wr_wait = 1'b1;
    build(va); send(0, 1'b0); idle(3);
    rst = 1'b1; idle(2);
    rst = 1'b0; wr_wait = 1'b0; idle(1);
    chk(wr_access == 1'b0 && link_wr_wait == 1'b0, "R12 reset clears buffer",
        {102'h0, wr_access, link_wr_wait}, 104'h0);

    summary();
  end

endmodule